// File: doc/BRIEF.md
# I2C Write-Only DAC Code Register Slave

This block sits behind the two-wire bus pins of a multi-channel converter. It watches the clock and data lines and answers only write transfers aimed at its own address. It drives the data line low through an open-drain enable whenever it acknowledges. When a transfer addresses it, the first byte after the address is an instruction. The instruction chooses how the following data bytes are steered and gives a 4-bit starting slot. Each data byte then lands in one of eight 6-bit code registers, which feed the converters continuously.

The three lowest address bits come from strap pins, so eight copies can share one bus. The instruction either steps the slot after every data byte or holds it fixed. The slot counter has sixteen positions, but only the first eight hold storage, so writes to the upper half are acknowledged and dropped. An instruction outside the two valid ranges is still acknowledged, but the data bytes that follow it change nothing. Both bus lines are oversampled by the system clock, and all decisions are taken on synchronised edges.

Top module: `i2c_dac_slave`

## Requirements
- R1: An address byte equal to {4'b0100, addr_strap_i[2:0], 1'b0} is acknowledged by asserting sda_oe_o during the ninth clock. Every other address byte is left unacknowledged, and so are all bytes after it until the next START.
- R2: An address byte whose upper seven bits match but whose last bit is 1 (read) is not acknowledged, and the rest of that transfer changes no register.
- R3: An instruction byte 0x00–0x0F selects stepping mode. The k-th data byte (k from 0) goes to slot (S + k) mod 16, where S is the instruction's low nibble.
- R4: An instruction byte 0xF0–0xFF selects fixed mode. Every data byte of the transfer goes to slot S.
- R5: Any other instruction byte is acknowledged, and so is every data byte that follows it, but no register changes.
- R6: Slot values 0–7 select register 0–7. Register i appears on dac_codes_o[6i+5:6i].
- R7: In stepping mode the slot wraps from 15 to 0. A data byte addressed to slot 8–15 changes no register.
- R8: Only bits [5:0] of a data byte are stored. Bits [7:6] are ignored.
- R9: Once the address matches, every instruction and data byte is acknowledged. A data byte's register value is visible on dac_codes_o while SCL is high in that byte's acknowledge clock.
- R10: A START or repeated START anywhere makes the next byte an address byte. A STOP returns the slave to idle with SDA released and all registers unchanged.
- R11: While rst_n is low at a clock edge, all registers become 0 and sda_oe_o becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the pad |
| addr_strap_i | input | 3 | Low three bits of the device address |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| dac_codes_o | output | NUM_REGS*CODE_W (48) | Packed code registers, register 0 in the lowest bits |

## Verification
The bench uses the default parameters: eight registers of six bits and a two-stage synchroniser. Bus phases last six system clocks, which leaves room for the edge detection delay. With eight real slots in a sixteen-position counter, a burst of about a dozen data bytes reaches the dead upper half and the wrap back to slot 0. The random transfers mix matching and non-matching addresses, the three instruction classes and bursts of one to six bytes, so fixed-mode writes into dead slots and repeated STARTs also occur.

// File: rtl/i2c_dac_pkg.sv
// Package: shared types and constants for the DAC code register slave.
// Assumes: a 7-bit bus address whose upper four bits are fixed.
package i2c_dac_pkg;

    // Fixed upper nibble of the write address byte
    localparam logic [3:0] DEV_ADDR_HI = 4'b0100;

    // Width of the slot counter carried in an instruction byte
    localparam int SLOT_W = 4;

    // Byte-level state of the bus link
    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_INSTR,
        LK_INSTR_ACK,
        LK_DATA,
        LK_DATA_ACK,
        LK_SKIP
    } link_state_t;

    // Steering mode chosen by the instruction byte
    typedef enum logic [1:0] {
        WM_NONE,
        WM_STEP,
        WM_FIXED
    } wr_mode_t;

endpackage

// File: rtl/i2c_dac_sync.sv
// Module: i2c_dac_sync
// Brings SCL and SDA into the clock domain through a flop chain. It then
// reports SCL edges and START/STOP conditions.
// Assumes: each bus phase lasts longer than STAGES+1 clock cycles, and both
// lines idle high, so the chain resets to 1.
module i2c_dac_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;

    // Synchroniser chains for both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    // One-cycle history of the synchronised levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_dac_link.sv
// Module: i2c_dac_link
// Byte engine. It shifts in bits on SCL rises and decides the acknowledge
// after the eighth bit. It matches the address and flags finished
// instruction and data bytes.
// Assumes: edge and condition pulses from i2c_dac_sync; write-only traffic.
module i2c_dac_link
    import i2c_dac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        sda_s,
    input  logic        start_det,
    input  logic        stop_det,
    input  logic [2:0]  addr_strap,
    output logic        sda_oe,
    output logic        instr_stb,
    output logic        data_stb,
    output logic [7:0]  rx_byte
);

    localparam int          BITS_PER_BYTE = 8;
    localparam logic [3:0]  LAST_BIT      = 4'(BITS_PER_BYTE);

    link_state_t state;
    logic [7:0]  shreg;
    logic [3:0]  bitcnt;
    logic        byte_done;
    logic        addr_hit;

    // Byte completion and address compare
    always_comb begin
        byte_done = scl_fall && (bitcnt == LAST_BIT);
        addr_hit  = (shreg[7:4] == DEV_ADDR_HI) && (shreg[3:1] == addr_strap)
                    && !shreg[0];
    end

    // Link state, shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= LK_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
        end else if (start_det) begin
            state  <= LK_ADDR;
            bitcnt <= '0;
        end else if (stop_det) begin
            state  <= LK_IDLE;
            bitcnt <= '0;
        end else begin
            case (state)
                LK_ADDR, LK_INSTR, LK_DATA: begin
                    if (scl_rise && bitcnt < LAST_BIT) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_done) begin
                        bitcnt <= '0;
                        if (state == LK_ADDR)
                            state <= addr_hit ? LK_ADDR_ACK : LK_SKIP;
                        else if (state == LK_INSTR)
                            state <= LK_INSTR_ACK;
                        else
                            state <= LK_DATA_ACK;
                    end
                end
                LK_ADDR_ACK:  if (scl_fall) state <= LK_INSTR;
                LK_INSTR_ACK: if (scl_fall) state <= LK_DATA;
                LK_DATA_ACK:  if (scl_fall) state <= LK_DATA;
                default: ;
            endcase
        end
    end

    // Outputs: pull-low during acknowledge slots, byte strobes
    always_comb begin
        sda_oe    = (state == LK_ADDR_ACK) || (state == LK_INSTR_ACK) ||
                    (state == LK_DATA_ACK);
        instr_stb = byte_done && (state == LK_INSTR) && !start_det && !stop_det;
        data_stb  = byte_done && (state == LK_DATA) && !start_det && !stop_det;
        rx_byte   = shreg;
    end

endmodule

// File: rtl/i2c_dac_cmd.sv
// Module: i2c_dac_cmd
// Decodes the instruction byte into a steering mode and a slot counter, and
// turns each data byte into a register write request.
// Assumes: one strobe per byte; NUM_REGS does not exceed 2**SLOT_W.
module i2c_dac_cmd
    import i2c_dac_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_stb,
    input  logic              data_stb,
    input  logic [7:0]        rx_byte,
    output wr_mode_t          mode,
    output logic [SLOT_W-1:0] slot,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx
);

    localparam int          HI_W    = 8 - SLOT_W;
    localparam logic [HI_W-1:0] STEP_HI = '0;
    localparam logic [HI_W-1:0] FIX_HI  = '1;

    wr_mode_t decoded;

    // Instruction class from the upper bits of the byte
    always_comb begin
        if (rx_byte[7:SLOT_W] == STEP_HI)
            decoded = WM_STEP;
        else if (rx_byte[7:SLOT_W] == FIX_HI)
            decoded = WM_FIXED;
        else
            decoded = WM_NONE;
    end

    // Mode and slot registers: loaded by instruction, stepped by data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= WM_NONE;
            slot <= '0;
        end else if (instr_stb) begin
            mode <= decoded;
            slot <= rx_byte[SLOT_W-1:0];
        end else if (data_stb && mode == WM_STEP) begin
            slot <= slot + 1'b1;
        end
    end

    // Write request for slots that hold storage
    always_comb begin
        wr_en  = data_stb && (mode != WM_NONE) && (int'(slot) < NUM_REGS);
        wr_idx = slot[IDX_W-1:0];
    end

endmodule

// File: rtl/i2c_dac_regfile.sv
// Module: i2c_dac_regfile
// Bank of code registers with one write port and packed parallel outputs.
// Assumes: wr_idx < NUM_REGS whenever wr_en is high.
module i2c_dac_regfile #(
    parameter int NUM_REGS = 8,
    parameter int CODE_W   = 6,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [7:0]                 wr_data,
    output logic [NUM_REGS*CODE_W-1:0] codes
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [CODE_W-1:0] value;

        // One code register; keeps only the low CODE_W bits of the byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                value <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                value <= wr_data[CODE_W-1:0];
        end

        assign codes[g*CODE_W +: CODE_W] = value;
    end

endmodule

// File: rtl/i2c_dac_slave.sv
// Module: i2c_dac_slave (top)
// Write-only two-wire slave that loads a bank of converter code registers.
// Assumes: the system clock runs well above the bus rate; SDA is open-drain
// outside the chip, and sda_oe_o pulls it low.
module i2c_dac_slave
    import i2c_dac_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int CODE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic [2:0]                 addr_strap_i,
    output logic                       sda_oe_o,
    output logic [NUM_REGS*CODE_W-1:0] dac_codes_o
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              instr_stb, data_stb, wr_en;
    logic [7:0]        rx_byte;
    wr_mode_t          mode;
    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  wr_idx;

    i2c_dac_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_dac_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_s      (sda_s),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_strap (addr_strap_i),
        .sda_oe     (sda_oe_o),
        .instr_stb  (instr_stb),
        .data_stb   (data_stb),
        .rx_byte    (rx_byte)
    );

    i2c_dac_cmd #(.NUM_REGS(NUM_REGS)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_stb (instr_stb),
        .data_stb  (data_stb),
        .rx_byte   (rx_byte),
        .mode      (mode),
        .slot      (slot),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx)
    );

    i2c_dac_regfile #(.NUM_REGS(NUM_REGS), .CODE_W(CODE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (rx_byte),
        .codes   (dac_codes_o)
    );

endmodule

// File: rtl/i2c_dac_slave_chk.sv
// Module: i2c_dac_slave_chk
// Property checker bound into the top. It watches the link strobes, the
// command state and the register outputs.
// Assumes: bound through the bind statement at the end of this file.
module i2c_dac_slave_chk
    import i2c_dac_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int CODE_W   = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scl_s,
    input logic                       sda_oe,
    input logic                       stop_det,
    input logic                       data_stb,
    input logic                       wr_en,
    input wr_mode_t                   mode,
    input logic [SLOT_W-1:0]          slot,
    input logic [NUM_REGS*CODE_W-1:0] codes
);

    // R5: data after an unrecognised instruction leaves the bank alone
    a_r5_bad_instr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && mode == WM_NONE) |=> $stable(codes));

    // R7: slots without storage absorb the byte
    a_r7_dead_slot_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && int'(slot) >= NUM_REGS) |=> $stable(codes));

    // R3: stepping mode advances the slot by one, wrapping
    a_r3_slot_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && mode == WM_STEP) |=> (slot == SLOT_W'($past(slot) + 1'b1)));

    // R4: fixed mode holds the slot
    a_r4_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && mode == WM_FIXED) |=> $stable(slot));

    // R9: each data byte is acknowledged in the next cycle
    a_r9_data_acked: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |=> sda_oe);

    // R9: the acknowledge level does not move while SCL is high
    a_r9_oe_steady_high_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R10: STOP leaves SDA released
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R6: registers only change after a write request
    a_r6_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(codes) |-> $past(wr_en));

endmodule

bind i2c_dac_slave i2c_dac_slave_chk #(.NUM_REGS(NUM_REGS), .CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe_o),
    .stop_det (stop_det),
    .data_stb (data_stb),
    .wr_en    (wr_en),
    .mode     (mode),
    .slot     (slot),
    .codes    (dac_codes_o)
);

// File: tb/i2c_dac_slave_tb.sv
// Bench: drives the bus as a master and tracks an expected register bank.
// It checks every acknowledge and the bank contents during each ack clock.
module i2c_dac_slave_tb;

    localparam int NREG = 8;
    localparam int CW   = 6;
    localparam int Q    = 6;   // clocks per quarter bus bit

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic [2:0]      strap = 3'd0;
    logic            sda_oe;
    logic [NREG*CW-1:0] codes;
    logic            sda_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [CW-1:0]      exp_reg [NREG];
    logic [NREG*CW-1:0] codes_at_ack;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_dac_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .addr_strap_i (strap),
        .sda_oe_o     (sda_oe),
        .dac_codes_o  (codes)
    );

    function automatic logic [NREG*CW-1:0] pack_exp();
        logic [NREG*CW-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*CW +: CW] = exp_reg[i];
        return v;
    endfunction

    function automatic int instr_class(logic [7:0] ins);  // 0 none,1 step,2 fixed
        if (ins[7:4] == 4'h0) return 1;
        if (ins[7:4] == 4'hF) return 2;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(Q);
            scl_m = 1'b1; wait_clk(2*Q);
            scl_m = 1'b0; wait_clk(Q);
        end
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        ack = sda_oe;
        codes_at_ack = codes;
        wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    // One transfer: START, address, instruction, data bytes, optional STOP
    task automatic xfer(input logic [7:0] addr, input logic [7:0] ins,
                        input logic [7:0] data [16], input int n,
                        input bit do_stop, input string req);
        bit ack;
        bit hit;
        int cls;
        logic [3:0] slot;
        hit = (addr == {4'b0100, strap, 1'b0});
        bus_start();
        send_byte(addr, ack);
        chk(ack == hit, {req, " R1 address ack"}, 64'(ack), 64'(hit));
        send_byte(ins, ack);
        chk(ack == hit, {req, " R9 instruction ack"}, 64'(ack), 64'(hit));
        cls  = instr_class(ins);
        slot = ins[3:0];
        for (int k = 0; k < n; k++) begin
            send_byte(data[k], ack);
            if (hit && cls != 0 && int'(slot) < NREG)
                exp_reg[slot[2:0]] = data[k][CW-1:0];
            chk(ack == hit, {req, " R9 data ack"}, 64'(ack), 64'(hit));
            chk(codes_at_ack == pack_exp(), {req, " R6 R9 codes at ack"},
                64'(codes_at_ack), 64'(pack_exp()));
            if (cls == 1) slot = slot + 4'd1;
        end
        if (do_stop) begin
            bus_stop();
            chk(sda_oe == 1'b0, {req, " R10 released after STOP"}, 64'(sda_oe), 0);
            chk(codes == pack_exp(), {req, " R10 codes kept after STOP"},
                64'(codes), 64'(pack_exp()));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d [16];
        bit ack;
        void'($urandom(32'd4242));
        for (int i = 0; i < NREG; i++) exp_reg[i] = '0;
        for (int i = 0; i < 16; i++) d[i] = '0;
        wait_clk(4);
        chk(codes == '0, "R11 codes zero in reset", 64'(codes), 0);
        chk(sda_oe == 1'b0, "R11 SDA released in reset", 64'(sda_oe), 0);
        rst_n = 1'b1;
        wait_clk(4);

        // R3 R8: stepping from slot 0, upper data bits set
        strap = 3'd0;
        for (int i = 0; i < 6; i++) d[i] = 8'(8'hC0 | (i * 7 + 3));
        xfer(8'h40, 8'h00, d, 6, 1'b1, "R3 R8 step from 0");
        chk(codes[5:0] == 6'h03, "R8 upper bits dropped", 64'(codes[5:0]), 64'h3);

        // R7: step from 6 through dead slots and wrap to 0,1
        strap = 3'd2;
        for (int i = 0; i < 12; i++) d[i] = 8'(8'h11 + i * 5);
        xfer(8'h44, 8'h06, d, 12, 1'b1, "R7 wrap through dead slots");
        chk(codes[5:0] == 6'(8'h11 + 10 * 5), "R7 wrapped to slot 0",
            64'(codes[5:0]), 64'(6'(8'h11 + 50)));

        // R4: fixed slot 3, last byte wins
        d[0] = 8'h2A; d[1] = 8'h15; d[2] = 8'h3C;
        xfer(8'h44, 8'hF3, d, 3, 1'b1, "R4 fixed slot");
        chk(codes[3*CW +: CW] == 6'h3C, "R4 fixed slot last value",
            64'(codes[3*CW +: CW]), 64'h3C);

        // R7: fixed mode on a dead slot
        xfer(8'h44, 8'hF9, d, 3, 1'b1, "R7 fixed dead slot");

        // R5: unrecognised instruction
        d[0] = 8'h01; d[1] = 8'h02;
        xfer(8'h44, 8'h35, d, 2, 1'b1, "R5 bad instruction");

        // R1: wrong strap, R2: read bit
        strap = 3'd5;
        xfer(8'h44, 8'h00, d, 2, 1'b1, "R1 wrong address");
        xfer(8'h4B, 8'h00, d, 2, 1'b1, "R2 read request");

        // R10: repeated START mid-transfer, then a fresh address
        d[0] = 8'h07; d[1] = 8'h08;
        xfer(8'h4A, 8'h01, d, 1, 1'b0, "R10 before repeated START");
        xfer(8'h4A, 8'hF2, d, 2, 1'b1, "R10 after repeated START");

        // R11: reset clears the bank
        wait_clk(2);
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        for (int i = 0; i < NREG; i++) exp_reg[i] = '0;
        wait_clk(1);
        chk(codes == '0, "R11 codes cleared by reset", 64'(codes), 0);
        chk(sda_oe == 1'b0, "R11 SDA released after reset", 64'(sda_oe), 0);

        // Random transfers
        for (int t = 0; t < 28; t++) begin
            logic [7:0] addr;
            logic [7:0] ins;
            int n;
            strap = 3'($urandom_range(0, 7));
            addr  = ($urandom_range(0, 3) != 0) ? {4'b0100, strap, 1'b0}
                                                 : 8'($urandom());
            case ($urandom_range(0, 2))
                0: ins = {4'h0, 4'($urandom())};
                1: ins = {4'hF, 4'($urandom())};
                default: ins = 8'($urandom());
            endcase
            n = $urandom_range(1, 6);
            for (int i = 0; i < 16; i++) d[i] = 8'($urandom());
            xfer(addr, ins, d, n, ($urandom_range(0, 4) != 0), "R3 R4 random");
        end
        bus_stop();
        chk(codes == pack_exp(), "R10 final bank", 64'(codes), 64'(pack_exp()));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

endmodule